// File: doc/BRIEF.md
# Least-Used Interrupt Link Allocator

This block hands out interrupt links to device interrupt pins while a system is being configured. Each accepted request yields one of eight links. The link is chosen either through a fixed formula on the slot and pin numbers, or by a search for the link with the fewest users so far. When the chosen link's routing register still holds its disabled reset value, the block also picks the legacy IRQ line with the lowest load. It then issues one write that binds the link to that IRQ.

Before the first request arrives, the block is in a cold phase. During this phase, single-cycle commands can raise the load of an IRQ or take an IRQ out of the pool altogether. The first accepted request ends the cold phase for good. After that, such commands are refused and flagged. A request is taken under a valid/ready handshake. The block scans one candidate per clock and reports the result with a single-cycle done pulse. The routing registers live outside the block. The block reads the chosen link's register through a combinational read port, and binds it through the write outputs that come with the done pulse.

Top module: `lla_top`

## Requirements
- R1: After reset every link has a use count of 0. IRQs 3, 4, 5, 6, 7, 9, 10, 11, 12, 14 and 15 (allowed mask 0xDEF8) carry load 0. All other IRQs of the 16 carry the exclusion marker 0xFF and are never bound.
- R2: A reserve command (`cmd_reserve`=1) in the cold phase sets the IRQ's load to 0xFF when its load is 0 or already 0xFF. Otherwise the command leaves the load unchanged and raises `cmd_err` in the following cycle.
- R3: A use command (`cmd_reserve`=0) in the cold phase adds one to the IRQ's load. It is refused with `cmd_err` in the following cycle, and changes nothing, when the load is 0xFF or would become 0xFF.
- R4: The first request accepted after reset ends the cold phase permanently. Any later reserve or use command changes no load and raises `cmd_err` one cycle after it is presented.
- R5: With `req_fixed`=1 the returned link is ((4 + slot + pin) mod 8) + 1.
- R6: With `req_fixed`=0 the returned link is the one with the smallest use count plus one. When several links share that count, the lowest-numbered one wins.
- R7: Every completed request adds one to the use count of the link it returns.
- R8: A binding is made only if the chosen link's routing register, read through `lnk_rd_idx`/`lnk_rd_val` (zero-based index), holds exactly 0x80. Any other value, including a disabled value with IRQ bits set, yields no write.
- R9: The bound IRQ is the one with the smallest load that is not 0xFF. Ties go to the lowest IRQ number. The bound IRQ's load then rises by one.
- R10: A binding appears as `wr_en`=1 in the done cycle, with `wr_data` equal to the IRQ number (bit 7 clear) for the register of link `done_link`.
- R11: If a binding is needed but every IRQ carries 0xFF, `alloc_err` is raised with the done pulse and `wr_en` stays low. The link is still returned and counted.
- R12: `req_ready` is high only while the block is idle. Each accepted request produces exactly one single-cycle `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A cold-phase command is presented this cycle |
| cmd_reserve | input | 1 | 1 = reserve (exclude) the IRQ, 0 = add one use |
| cmd_irq | input | 4 | IRQ number the command applies to |
| cmd_err | output | 1 | Pulse: the previous cycle's command was refused |
| req_valid | input | 1 | Allocation request valid |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_slot | input | 5 | Device slot number |
| req_pin | input | 3 | Device interrupt pin number |
| req_fixed | input | 1 | 1 = fixed-formula link, 0 = least-used link |
| done | output | 1 | Pulse: result of the accepted request |
| done_link | output | 4 | Returned link, 1 to 8 |
| alloc_err | output | 1 | Binding needed but no IRQ available |
| wr_en | output | 1 | Write `wr_data` into the register of `done_link` |
| wr_data | output | 8 | New routing register value |
| lnk_rd_idx | output | 3 | Zero-based link whose routing register is read |
| lnk_rd_val | input | 8 | Routing register value of link `lnk_rd_idx` |

## Verification
The assertions take for granted that `lnk_rd_val` reflects a routing register that changes only through this block's own writes or between requests, and that `cmd_irq` always names one of the 16 IRQs. They also assume reset is applied before the first command. The bench keeps its router model updated only at done pulses. It alters that model by hand only while the block is idle, to create links that are disabled in other ways or that are freshly disabled. It presents every command for exactly one cycle, and it holds the request fields only for the accepting cycle, which is all the block samples.

// File: rtl/lla_pkg.sv
// Shared constants and state encoding for the link allocator.
package lla_pkg;
    localparam logic [7:0] LINK_OFF_VAL = 8'h80; // disabled reset value of a link register

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LSCAN = 3'd1,
        ST_BIND  = 3'd2,
        ST_ISCAN = 3'd3,
        ST_FIN   = 3'd4
    } lla_state_e;
endpackage

// File: rtl/lla_min_track.sv
// Running minimum tracker: fed one candidate per step, it keeps the index of
// the smallest value seen since the last clear. Strict less-than keeps the
// earliest index on ties. Assumes candidates arrive in ascending index order.
module lla_min_track #(
    parameter int IDX_W = 3,
    parameter int VAL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             skip,
    input  logic [IDX_W-1:0] cand_idx,
    input  logic [VAL_W-1:0] cand_val,
    output logic [IDX_W-1:0] best_idx,
    output logic             found
);
    logic [VAL_W-1:0] best_val;

    // Track the smallest non-skipped candidate.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            best_idx <= '0;
            best_val <= '0;
            found    <= 1'b0;
        end else if (step && !skip && (!found || cand_val < best_val)) begin
            best_idx <= cand_idx;
            best_val <= cand_val;
            found    <= 1'b1;
        end
    end
endmodule

// File: rtl/lla_link_cnt.sv
// Per-link use counters with one read port and one increment port.
// Counters saturate at their maximum value instead of wrapping.
module lla_link_cnt #(
    parameter int NUM_LINKS = 8,
    parameter int CNT_W     = 8,
    localparam int LINK_W   = $clog2(NUM_LINKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINK_W-1:0] rd_idx,
    output logic [CNT_W-1:0]  rd_val,
    input  logic              inc_en,
    input  logic [LINK_W-1:0] inc_idx
);
    logic [CNT_W-1:0] cnt_q [NUM_LINKS];

    // Clear on reset, count one use per increment strobe.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_LINKS; i++) begin
            if (!rst_n)
                cnt_q[i] <= '0;
            else if (inc_en && inc_idx == LINK_W'(i) && cnt_q[i] != '1)
                cnt_q[i] <= cnt_q[i] + 1'b1;
        end
    end

    // Combinational read for the scanner.
    assign rd_val = cnt_q[rd_idx];
endmodule

// File: rtl/lla_irq_tab.sv
// IRQ load table. Holds one load value per IRQ, the all-ones value meaning
// excluded. Applies cold-phase reserve/use commands and refuses illegal ones
// with a registered error pulse. Assumes binding increments never coincide
// with an accepted command (bindings occur only after the cold phase).
module lla_irq_tab #(
    parameter int                NUM_IRQS = 16,
    parameter int                LOAD_W   = 8,
    parameter logic [NUM_IRQS-1:0] ALLOWED = 16'hDEF8,
    localparam int               IRQ_W    = $clog2(NUM_IRQS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cold,
    input  logic              cmd_valid,
    input  logic              cmd_reserve,
    input  logic [IRQ_W-1:0]  cmd_irq,
    output logic              cmd_err,
    input  logic [IRQ_W-1:0]  rd_idx,
    output logic [LOAD_W-1:0] rd_val,
    input  logic              inc_en,
    input  logic [IRQ_W-1:0]  inc_idx
);
    localparam logic [LOAD_W-1:0] EXCL = '1;
    localparam logic [LOAD_W-1:0] TOP  = EXCL - 1'b1;

    logic [LOAD_W-1:0] load_q [NUM_IRQS];
    logic [LOAD_W-1:0] cmd_cur;
    logic              cmd_ok;

    assign cmd_cur = load_q[cmd_irq];

    // Legality of the presented command.
    always_comb begin
        if (!cold || !cmd_valid)
            cmd_ok = 1'b0;
        else if (cmd_reserve)
            cmd_ok = (cmd_cur == '0) || (cmd_cur == EXCL);
        else
            cmd_ok = (cmd_cur < TOP);
    end

    // Load table update from commands and bindings.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_IRQS; i++) begin
            if (!rst_n)
                load_q[i] <= ALLOWED[i] ? '0 : EXCL;
            else if (cmd_ok && cmd_irq == IRQ_W'(i))
                load_q[i] <= cmd_reserve ? EXCL : load_q[i] + 1'b1;
            else if (inc_en && inc_idx == IRQ_W'(i) && load_q[i] < TOP)
                load_q[i] <= load_q[i] + 1'b1;
        end
    end

    // Registered refusal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_err <= 1'b0;
        else
            cmd_err <= cmd_valid && !cmd_ok;
    end

    assign rd_val = load_q[rd_idx];
endmodule

// File: rtl/lla_ctrl.sv
// Request sequencer: accepts a request, chooses a link (fixed formula or one
// scan step per link), reads its routing register, scans IRQs one per clock
// when a binding is needed, then emits a single-cycle result.
// Assumes NUM_LINKS is a power of two so the fixed formula is a bit slice.
module lla_ctrl
    import lla_pkg::*;
#(
    parameter int NUM_LINKS = 8,
    parameter int NUM_IRQS  = 16,
    parameter int SLOT_W    = 5,
    parameter int PIN_W     = 3,
    parameter int FIX_BASE  = 4,
    parameter int REG_W     = 8,
    localparam int LINK_W   = $clog2(NUM_LINKS),
    localparam int IRQ_W    = $clog2(NUM_IRQS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SLOT_W-1:0] req_slot,
    input  logic [PIN_W-1:0]  req_pin,
    input  logic              req_fixed,
    output logic              cold,
    output logic              lscan_clr,
    output logic              lscan_step,
    output logic [LINK_W-1:0] lscan_idx,
    input  logic [LINK_W-1:0] lbest_idx,
    input  logic              lfound,
    output logic              link_inc_en,
    output logic [LINK_W-1:0] pick,
    input  logic [REG_W-1:0]  lnk_rd_val,
    output logic              iscan_clr,
    output logic              iscan_step,
    output logic [IRQ_W-1:0]  iscan_idx,
    input  logic [IRQ_W-1:0]  ibest_idx,
    input  logic              ifound,
    output logic              irq_inc_en,
    output logic              done,
    output logic [LINK_W:0]   done_link,
    output logic              alloc_err,
    output logic              wr_en,
    output logic [REG_W-1:0]  wr_data
);
    localparam int SUM_W = SLOT_W + 1;

    lla_state_e        st;
    logic              fixed_r;
    logic [LINK_W-1:0] fix_r;
    logic [LINK_W-1:0] link_r;
    logic              bind_r;
    logic [SUM_W-1:0]  fsum;

    // Fixed-mapping sum; the low bits give the link modulo NUM_LINKS.
    assign fsum = SUM_W'(FIX_BASE) + {1'b0, req_slot} + SUM_W'(req_pin);

    // Strobes and indices derived from the state.
    assign req_ready   = (st == ST_IDLE);
    assign lscan_clr   = (st == ST_IDLE);
    assign lscan_step  = (st == ST_LSCAN);
    assign iscan_clr   = (st == ST_BIND);
    assign iscan_step  = (st == ST_ISCAN);
    assign link_inc_en = (st == ST_BIND);
    assign irq_inc_en  = (st == ST_FIN) && bind_r && ifound;
    assign pick        = fixed_r ? fix_r : (lfound ? lbest_idx : '0);

    // Sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cold      <= 1'b1;
            fixed_r   <= 1'b0;
            fix_r     <= '0;
            link_r    <= '0;
            bind_r    <= 1'b0;
            lscan_idx <= '0;
            iscan_idx <= '0;
            done      <= 1'b0;
            done_link <= '0;
            alloc_err <= 1'b0;
            wr_en     <= 1'b0;
            wr_data   <= '0;
        end else begin
            done      <= 1'b0;
            alloc_err <= 1'b0;
            wr_en     <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        cold      <= 1'b0;
                        fixed_r   <= req_fixed;
                        fix_r     <= fsum[LINK_W-1:0];
                        lscan_idx <= '0;
                        st        <= req_fixed ? ST_BIND : ST_LSCAN;
                    end
                end
                ST_LSCAN: begin
                    lscan_idx <= lscan_idx + 1'b1;
                    if (lscan_idx == LINK_W'(NUM_LINKS - 1))
                        st <= ST_BIND;
                end
                ST_BIND: begin
                    link_r <= pick;
                    if (lnk_rd_val == LINK_OFF_VAL) begin
                        bind_r    <= 1'b1;
                        iscan_idx <= '0;
                        st        <= ST_ISCAN;
                    end else begin
                        bind_r <= 1'b0;
                        st     <= ST_FIN;
                    end
                end
                ST_ISCAN: begin
                    iscan_idx <= iscan_idx + 1'b1;
                    if (iscan_idx == IRQ_W'(NUM_IRQS - 1))
                        st <= ST_FIN;
                end
                ST_FIN: begin
                    done      <= 1'b1;
                    done_link <= (LINK_W+1)'(link_r) + (LINK_W+1)'(1);
                    wr_en     <= bind_r && ifound;
                    wr_data   <= REG_W'(ibest_idx);
                    alloc_err <= bind_r && !ifound;
                    st        <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lla_top.sv
// Least-used interrupt link allocator top. Wires the sequencer to the link
// counters, the IRQ load table and two minimum trackers. Assumes the routing
// register read through lnk_rd_idx answers combinationally.
module lla_top #(
    parameter int                  NUM_LINKS = 8,
    parameter int                  NUM_IRQS  = 16,
    parameter int                  CNT_W     = 8,
    parameter int                  LOAD_W    = 8,
    parameter int                  SLOT_W    = 5,
    parameter int                  PIN_W     = 3,
    parameter int                  FIX_BASE  = 4,
    parameter int                  REG_W     = 8,
    parameter logic [NUM_IRQS-1:0] ALLOWED   = 16'hDEF8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid,
    input  logic                          cmd_reserve,
    input  logic [$clog2(NUM_IRQS)-1:0]   cmd_irq,
    output logic                          cmd_err,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [SLOT_W-1:0]             req_slot,
    input  logic [PIN_W-1:0]              req_pin,
    input  logic                          req_fixed,
    output logic                          done,
    output logic [$clog2(NUM_LINKS):0]    done_link,
    output logic                          alloc_err,
    output logic                          wr_en,
    output logic [REG_W-1:0]              wr_data,
    output logic [$clog2(NUM_LINKS)-1:0]  lnk_rd_idx,
    input  logic [REG_W-1:0]              lnk_rd_val
);
    localparam int LINK_W = $clog2(NUM_LINKS);
    localparam int IRQ_W  = $clog2(NUM_IRQS);

    logic              cold;
    logic              lscan_clr, lscan_step, lfound, link_inc_en;
    logic [LINK_W-1:0] lscan_idx, lbest_idx, pick;
    logic [CNT_W-1:0]  link_val;
    logic              iscan_clr, iscan_step, ifound, irq_inc_en, irq_skip;
    logic [IRQ_W-1:0]  iscan_idx, ibest_idx;
    logic [LOAD_W-1:0] irq_val;

    assign lnk_rd_idx = pick;
    assign irq_skip   = (irq_val == '1);

    lla_ctrl #(
        .NUM_LINKS(NUM_LINKS), .NUM_IRQS(NUM_IRQS), .SLOT_W(SLOT_W),
        .PIN_W(PIN_W), .FIX_BASE(FIX_BASE), .REG_W(REG_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_slot(req_slot),
        .req_pin(req_pin), .req_fixed(req_fixed), .cold(cold),
        .lscan_clr(lscan_clr), .lscan_step(lscan_step), .lscan_idx(lscan_idx),
        .lbest_idx(lbest_idx), .lfound(lfound), .link_inc_en(link_inc_en),
        .pick(pick), .lnk_rd_val(lnk_rd_val),
        .iscan_clr(iscan_clr), .iscan_step(iscan_step), .iscan_idx(iscan_idx),
        .ibest_idx(ibest_idx), .ifound(ifound), .irq_inc_en(irq_inc_en),
        .done(done), .done_link(done_link), .alloc_err(alloc_err),
        .wr_en(wr_en), .wr_data(wr_data)
    );

    lla_link_cnt #(.NUM_LINKS(NUM_LINKS), .CNT_W(CNT_W)) u_links (
        .clk(clk), .rst_n(rst_n), .rd_idx(lscan_idx), .rd_val(link_val),
        .inc_en(link_inc_en), .inc_idx(pick)
    );

    lla_irq_tab #(.NUM_IRQS(NUM_IRQS), .LOAD_W(LOAD_W), .ALLOWED(ALLOWED)) u_irqs (
        .clk(clk), .rst_n(rst_n), .cold(cold), .cmd_valid(cmd_valid),
        .cmd_reserve(cmd_reserve), .cmd_irq(cmd_irq), .cmd_err(cmd_err),
        .rd_idx(iscan_idx), .rd_val(irq_val),
        .inc_en(irq_inc_en), .inc_idx(ibest_idx)
    );

    lla_min_track #(.IDX_W(LINK_W), .VAL_W(CNT_W)) u_lmin (
        .clk(clk), .rst_n(rst_n), .clr(lscan_clr), .step(lscan_step),
        .skip(1'b0), .cand_idx(lscan_idx), .cand_val(link_val),
        .best_idx(lbest_idx), .found(lfound)
    );

    lla_min_track #(.IDX_W(IRQ_W), .VAL_W(LOAD_W)) u_imin (
        .clk(clk), .rst_n(rst_n), .clr(iscan_clr), .step(iscan_step),
        .skip(irq_skip), .cand_idx(iscan_idx), .cand_val(irq_val),
        .best_idx(ibest_idx), .found(ifound)
    );
endmodule

// File: rtl/lla_chk.sv
// Protocol checker for lla_top, attached by bind. Observes ports and the
// cold-phase flag only.
module lla_chk #(
    parameter int                  NUM_LINKS = 8,
    parameter int                  NUM_IRQS  = 16,
    parameter int                  REG_W     = 8,
    parameter logic [NUM_IRQS-1:0] ALLOWED   = 16'hDEF8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cold,
    input logic                         cmd_valid,
    input logic                         cmd_err,
    input logic                         req_valid,
    input logic                         req_ready,
    input logic                         done,
    input logic [$clog2(NUM_LINKS):0]   done_link,
    input logic                         alloc_err,
    input logic                         wr_en,
    input logic [REG_W-1:0]             wr_data
);
    localparam int IRQ_W = $clog2(NUM_IRQS);

    AST_COLD_ENDS_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !cold); // R4
    AST_COLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !cold |=> !cold); // R4
    AST_WARM_CMD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cold && cmd_valid) |=> cmd_err); // R4
    AST_LINK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_link >= 1 && done_link <= ($clog2(NUM_LINKS)+1)'(NUM_LINKS))); // R6
    AST_WRITE_PLAIN_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data < REG_W'(NUM_IRQS) && ALLOWED[wr_data[IRQ_W-1:0]])); // R10
    AST_WRITE_NOT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (done && !alloc_err)); // R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R12
endmodule

bind lla_top lla_chk #(
    .NUM_LINKS(NUM_LINKS), .NUM_IRQS(NUM_IRQS), .REG_W(REG_W), .ALLOWED(ALLOWED)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cold(cold), .cmd_valid(cmd_valid),
    .cmd_err(cmd_err), .req_valid(req_valid), .req_ready(req_ready),
    .done(done), .done_link(done_link), .alloc_err(alloc_err),
    .wr_en(wr_en), .wr_data(wr_data)
);

// File: tb/tb_lla_top.sv
// Directed bench for lla_top with a model of the eight routing registers.
module tb_lla_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_reserve = 1'b0;
    logic [3:0] cmd_irq = '0;
    logic       cmd_err;
    logic       req_valid = 1'b0, req_ready, req_fixed = 1'b0;
    logic [4:0] req_slot = '0;
    logic [2:0] req_pin = '0;
    logic       done, alloc_err, wr_en;
    logic [3:0] done_link;
    logic [7:0] wr_data;
    logic [2:0] lnk_rd_idx;
    logic [7:0] lnk_rd_val;
    logic [7:0] rtr [8];

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign lnk_rd_val = rtr[lnk_rd_idx];

    lla_top dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_reserve(cmd_reserve),
        .cmd_irq(cmd_irq), .cmd_err(cmd_err), .req_valid(req_valid),
        .req_ready(req_ready), .req_slot(req_slot), .req_pin(req_pin),
        .req_fixed(req_fixed), .done(done), .done_link(done_link),
        .alloc_err(alloc_err), .wr_en(wr_en), .wr_data(wr_data),
        .lnk_rd_idx(lnk_rd_idx), .lnk_rd_val(lnk_rd_val)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 8; i++) rtr[i] = 8'h80;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One-cycle command; cmd_err is checked in the following cycle.
    task automatic cmd(input logic rsv, input int irq, input int exp_err, input string tag);
        cmd_valid = 1'b1;
        cmd_reserve = rsv;
        cmd_irq = 4'(irq);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(tag, int'(cmd_err), exp_err);
    endtask

    // One request; checks busy, the result fields and the single done pulse.
    task automatic alloc(input int slot, input int pin, input logic fixed, input int exp_link,
                         input int exp_wr, input int exp_irq, input int exp_err, input string tag);
        int n;
        req_valid = 1'b1;
        req_slot = 5'(slot);
        req_pin = 3'(pin);
        req_fixed = fixed;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R12 ready low while busy"}, int'(req_ready), 0);
        n = 0;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " R12 done seen"}, int'(done), 1);
        chk({tag, " link"}, int'(done_link), exp_link);
        chk({tag, " wr_en"}, int'(wr_en), exp_wr);
        if (exp_wr != 0) chk({tag, " R10 wr_data"}, int'(wr_data), exp_irq);
        chk({tag, " R11 alloc_err"}, int'(alloc_err), exp_err);
        if (wr_en && done_link >= 1 && done_link <= 8) rtr[done_link - 1] = wr_data;
        @(negedge clk);
        chk({tag, " R12 done single pulse"}, int'(done), 0);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 reset cmd_err", int'(cmd_err), 0);
        chk("R12 reset ready", int'(req_ready), 1);
        chk("R12 reset done", int'(done), 0);
    endtask

    task automatic t_cold_cmds();
        cmd(1'b1, 3, 0, "R2 reserve free irq3");
        cmd(1'b0, 4, 0, "R3 use irq4");
        cmd(1'b1, 4, 1, "R2 reserve loaded irq4 refused");
        cmd(1'b0, 8, 1, "R3 use excluded irq8 refused");
        cmd(1'b1, 8, 0, "R2 reserve already excluded irq8");
    endtask

    task automatic t_bind_sequence();
        rtr[1] = 8'h85;
        alloc(0, 1, 1'b0, 1, 1, 5, 0, "R9 first bind skips irq3 and loaded irq4");
        cmd(1'b1, 7, 1, "R4 reserve after cold");
        cmd(1'b0, 6, 1, "R4 use after cold");
        alloc(0, 1, 1'b0, 2, 0, 0, 0, "R8 link2 reg 0x85 not bound");
        alloc(0, 1, 1'b0, 3, 1, 6, 0, "R4 ignored use irq6");
        alloc(0, 1, 1'b0, 4, 1, 7, 0, "R4 ignored reserve irq7");
        alloc(0, 1, 1'b0, 5, 1, 9, 0, "R1 irq8 excluded");
        alloc(0, 1, 1'b0, 6, 1, 10, 0, "R6 next link");
        alloc(0, 1, 1'b0, 7, 1, 11, 0, "R7 counts rise");
        alloc(0, 1, 1'b0, 8, 1, 12, 0, "R9 irq12");
    endtask

    task automatic t_fixed_and_tie();
        alloc(2, 1, 1'b1, 8, 0, 0, 0, "R5 fixed 4+2+1 bound link");
        alloc(0, 4, 1'b1, 1, 0, 0, 0, "R5 fixed wraps to link1");
        alloc(0, 1, 1'b0, 2, 0, 0, 0, "R6 lowest least-used link2");
        rtr[2] = 8'h80;
        alloc(0, 1, 1'b0, 3, 1, 14, 0, "R8 rebind disabled link3");
        rtr[3] = 8'h80;
        alloc(0, 1, 1'b0, 4, 1, 15, 0, "R9 irq15 last zero load");
        rtr[4] = 8'h80;
        alloc(0, 1, 1'b0, 5, 1, 4, 0, "R9 tie goes to irq4");
    endtask

    task automatic t_exhaust();
        int allowed [11] = '{3, 4, 5, 6, 7, 9, 10, 11, 12, 14, 15};
        do_reset();
        foreach (allowed[i]) cmd(1'b1, allowed[i], 0, "R2 reserve every allowed irq");
        cmd(1'b0, 0, 1, "R1 irq0 excluded at reset");
        alloc(31, 1, 1'b1, 5, 0, 0, 1, "R11 fixed slot31 no irq left");
        alloc(0, 2, 1'b0, 1, 0, 0, 1, "R11 search no irq left");
        alloc(0, 2, 1'b0, 2, 0, 0, 1, "R7 counted link skipped");
        cmd(1'b0, 5, 1, "R4 use refused after first request");
    endtask

    initial begin
        t_reset_state();
        t_cold_cmds();
        t_bind_sequence();
        t_fixed_and_tie();
        t_exhaust();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule